// File: doc/BRIEF.md
# Dual-Bank Glitch-Free Clock Root

This block produces one root clock from a set of free-running source clocks. It keeps two complete configuration banks. Each bank holds a source code, a pre-divider and fractional M/N/D fields. A single select bit decides which bank's divided clock reaches the output, and that choice passes through a glitch-free two-input clock mux. A one-cycle request on the configuration port starts a fixed write sequence. While the root runs, the sequence fills the idle bank and then flips the select bit, so the bank that drives the output is never touched. While the root is stopped, the sequence rewrites the active bank in place and the select bit stays where it is.

A sequencer FSM clocked by the system clock `clk` runs these states. `ST_IDLE` accepts a request. `ST_RST` raises the counter hold of the target bank. `ST_MD` writes M and D. `ST_N` writes the encoded N. `ST_MODE` writes the dual-edge enable. `ST_REL` drops the counter hold. `ST_SRC` writes the source code and the divider. `ST_FLIP` toggles the select bit. `ST_WAIT` waits until the mux has handed over. The transitions are as follows. IDLE goes to RST on a request. RST, MD, N, MODE, REL and SRC then follow one another. SRC goes to FLIP when the request arrived with the root running, and back to IDLE otherwise. FLIP goes to WAIT. WAIT goes to IDLE once the new bank holds the grant and the old bank has released it, or at once if the root is stopped. The read-back outputs always show the fields of the selected bank only.

Top module: `dual_bank_clkroot`

## Requirements
- R1: After reset, bank 0 is selected, `busy` and `switch_pending` are low, and every read-back field is zero.
- R2: `bank_sel`=1 means bank 1 drives the output and the read-back; 0 means bank 0. A request accepted while `root_en`=1 targets the other bank, and `bank_sel` toggles on the 7th rising edge after the accepting edge.
- R3: While `root_en`=1, a request never changes the fields of the selected bank: the read-back stays unchanged until the select bit toggles.
- R4: A request accepted while `root_en`=0 rewrites the selected bank in place and leaves `bank_sel` unchanged. Counting the accepting edge as edge 0, `busy` falls after edge 6.
- R5: The write order is fixed. Edge 1 raises the hold, edge 2 writes M and D, edge 3 writes N, edge 4 writes the dual flag, edge 5 releases the hold, and edge 6 writes the source code and the divider. The select bit toggles only after that.
- R6: The 2-bit logical parent index maps to a 3-bit source code: 0→5, 1→2, 2→7, 3→0. Source code k selects `src_clk[k]`.
- R7: The divider field holds divisor−1, and a divisor of 0 is stored as 1. The output period is divisor × the selected source period.
- R8: When N≠0, the bank stores M, an N field of ~(N−M) and a D field of ~N, each MN_W bits wide, and it sets the dual flag. `rd_n` reads back ~Nfield+M. When N=0, M, N, D and the dual flag are all cleared and `rd_n` reads 0.
- R9: A request that arrives while `busy` is high is ignored.
- R10: The two mux grants are never high together. When `root_en`=0, both grants drop and `clk_out` stays low.
- R11: `switch_pending` is high from the toggle until the handover ends, and `busy` stays high during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_en | input | 1 | Root running (1) or stopped (0) |
| src_clk | input | 8 | Free-running source clocks, indexed by source code |
| cfg_req | input | 1 | One-cycle configuration request |
| cfg_parent | input | 2 | Logical parent index |
| cfg_div | input | DIV_W | Pre-divisor (0 treated as 1) |
| cfg_m | input | MN_W | M value |
| cfg_n | input | MN_W | N value (0 disables M/N) |
| busy | output | 1 | Sequence in progress |
| switch_pending | output | 1 | Bank handover not yet complete |
| bank_sel | output | 1 | Selected bank |
| rd_src | output | 3 | Source code of the selected bank |
| rd_div | output | DIV_W | Divider field of the selected bank |
| rd_m | output | MN_W | M of the selected bank |
| rd_n | output | MN_W | Decoded N of the selected bank |
| rd_d | output | MN_W | D field of the selected bank |
| rd_dual | output | 1 | Dual-edge flag of the selected bank |
| rd_mn_hold | output | 1 | Counter hold of the selected bank |
| clk_out | output | 1 | Root clock |

## Verification
Each register update is due on a known edge, counted from the edge that accepts the request. Hold, M/D, N, dual, release and source/divider land on edges 1 to 6, and the select toggle lands on edge 7. The reference model applies each update on the same edge and compares every output half a period later, on the falling edge. The end of the handover depends on the phases of the source clocks, so the model stops predicting `busy` there. It expects `switch_pending` to stay high until `busy` falls. Clock periods and the quiet output are measured only after the sequence has finished and 20 further cycles have passed.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;
    localparam int SRC_CODE_W = 3;
    localparam int NUM_SRC_CLK = 1 << SRC_CODE_W;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RST, ST_MD, ST_N, ST_MODE, ST_REL, ST_SRC, ST_FLIP, ST_WAIT
    } seq_state_t;
endpackage

// File: rtl/clkroot_seq.sv
module clkroot_seq
    import clkroot_pkg::*;
#(
    parameter int DIV_W = 4,
    parameter int MN_W = 8,
    parameter int NUM_PARENT = 4,
    parameter int PAR_W = $clog2(NUM_PARENT),
    parameter logic [NUM_PARENT*SRC_CODE_W-1:0] PARENT_MAP = {3'd0, 3'd7, 3'd2, 3'd5},
    parameter bit HAS_MN = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         root_en,
    input  logic                         cfg_req,
    input  logic [PAR_W-1:0]             cfg_parent,
    input  logic [DIV_W-1:0]             cfg_div,
    input  logic [MN_W-1:0]              cfg_m,
    input  logic [MN_W-1:0]              cfg_n,
    input  logic                         handover_done,
    output seq_state_t                   state,
    output logic                         tgt,
    output logic                         run,
    output logic                         bank_sel,
    output logic [1:0][SRC_CODE_W-1:0]   src_code,
    output logic [1:0][DIV_W-1:0]        div_f,
    output logic [1:0][MN_W-1:0]         m_f,
    output logic [1:0][MN_W-1:0]         n_f,
    output logic [1:0][MN_W-1:0]         d_f,
    output logic [1:0]                   dual,
    output logic [1:0]                   ctr_hold
);
    seq_state_t nxt;
    logic [SRC_CODE_W-1:0] req_code;
    logic [DIV_W-1:0]      req_div;
    logic [MN_W-1:0]       req_m, req_nf, req_d;
    logic                  req_dual;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (cfg_req) nxt = HAS_MN ? ST_RST : ST_SRC;
            ST_RST:  nxt = ST_MD;
            ST_MD:   nxt = ST_N;
            ST_N:    nxt = ST_MODE;
            ST_MODE: nxt = ST_REL;
            ST_REL:  nxt = ST_SRC;
            ST_SRC:  nxt = run ? ST_FLIP : ST_IDLE;
            ST_FLIP: nxt = ST_WAIT;
            ST_WAIT: if (handover_done || !root_en) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // bank writes and select, one field group per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_sel <= 1'b0;  tgt <= 1'b0;  run <= 1'b0;
            req_code <= '0;    req_div <= '0;
            req_m <= '0;       req_nf <= '0;  req_d <= '0;  req_dual <= 1'b0;
            src_code <= '0;    div_f <= '0;   m_f <= '0;    n_f <= '0;
            d_f <= '0;         dual <= '0;    ctr_hold <= '0;
        end else begin
            case (state)
                ST_IDLE: if (cfg_req) begin
                    req_code <= PARENT_MAP[int'(cfg_parent)*SRC_CODE_W +: SRC_CODE_W];
                    req_div  <= (cfg_div == '0) ? '0 : cfg_div - 1'b1;
                    if (cfg_n != '0) begin
                        req_m    <= cfg_m;
                        req_nf   <= ~(cfg_n - cfg_m);
                        req_d    <= ~cfg_n;
                        req_dual <= 1'b1;
                    end else begin
                        req_m <= '0;  req_nf <= '0;  req_d <= '0;  req_dual <= 1'b0;
                    end
                    tgt <= root_en ? ~bank_sel : bank_sel;
                    run <= root_en;
                end
                ST_RST:  ctr_hold[tgt] <= 1'b1;
                ST_MD:   begin m_f[tgt] <= req_m; d_f[tgt] <= req_d; end
                ST_N:    n_f[tgt] <= req_nf;
                ST_MODE: dual[tgt] <= req_dual;
                ST_REL:  ctr_hold[tgt] <= 1'b0;
                ST_SRC:  begin src_code[tgt] <= req_code; div_f[tgt] <= req_div; end
                ST_FLIP: bank_sel <= ~bank_sel;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/clkroot_bank_div.sv
module clkroot_bank_div
    import clkroot_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic                   rst_n,
    input  logic [NUM_SRC_CLK-1:0] src_clk,
    input  logic [SRC_CODE_W-1:0]  code,
    input  logic [DIV_W-1:0]       div,
    output logic                   bank_clk
);
    logic             sclk;
    logic [DIV_W-1:0] cnt, cnt_nx;
    logic [DIV_W:0]   half;
    logic             q;

    assign sclk = src_clk[code];
    assign half = ({1'b0, div} + 2'd2) >> 1;

    always_comb cnt_nx = (cnt >= div) ? '0 : cnt + 1'b1;

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            q   <= 1'b0;
        end else begin
            cnt <= cnt_nx;
            q   <= ({1'b0, cnt_nx} < half);
        end
    end

    assign bank_clk = (div == '0) ? sclk : q;
endmodule

// File: rtl/clkroot_gfmux.sv
module clkroot_gfmux (
    input  logic       rst_n,
    input  logic [1:0] bclk,
    input  logic [1:0] want,
    output logic [1:0] gnt,
    output logic       clk_out
);
    for (genvar i = 0; i < 2; i++) begin : g_side
        logic s1_q, g_q;
        always_ff @(posedge bclk[i] or negedge rst_n) begin
            if (!rst_n) s1_q <= 1'b0;
            else        s1_q <= want[i] & ~gnt[1-i];
        end
        always_ff @(negedge bclk[i] or negedge rst_n) begin
            if (!rst_n) g_q <= 1'b0;
            else        g_q <= s1_q;
        end
        assign gnt[i] = g_q;
    end

    assign clk_out = |(bclk & gnt);
endmodule

// File: rtl/dual_bank_clkroot.sv
module dual_bank_clkroot
    import clkroot_pkg::*;
#(
    parameter int DIV_W = 4,
    parameter int MN_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   root_en,
    input  logic [NUM_SRC_CLK-1:0] src_clk,
    input  logic                   cfg_req,
    input  logic [1:0]             cfg_parent,
    input  logic [DIV_W-1:0]       cfg_div,
    input  logic [MN_W-1:0]        cfg_m,
    input  logic [MN_W-1:0]        cfg_n,
    output logic                   busy,
    output logic                   switch_pending,
    output logic                   bank_sel,
    output logic [SRC_CODE_W-1:0]  rd_src,
    output logic [DIV_W-1:0]       rd_div,
    output logic [MN_W-1:0]        rd_m,
    output logic [MN_W-1:0]        rd_n,
    output logic [MN_W-1:0]        rd_d,
    output logic                   rd_dual,
    output logic                   rd_mn_hold,
    output logic                   clk_out
);
    seq_state_t                 seq_state;
    logic                       seq_tgt, seq_run, handover_done;
    logic [1:0][SRC_CODE_W-1:0] src_code;
    logic [1:0][DIV_W-1:0]      div_f;
    logic [1:0][MN_W-1:0]       m_f, n_f, d_f;
    logic [1:0]                 dual, ctr_hold, bclk, want, mux_gnt;
    logic [1:0]                 gs1, gs2;

    clkroot_seq #(.DIV_W(DIV_W), .MN_W(MN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .root_en(root_en), .cfg_req(cfg_req),
        .cfg_parent(cfg_parent), .cfg_div(cfg_div), .cfg_m(cfg_m), .cfg_n(cfg_n),
        .handover_done(handover_done), .state(seq_state), .tgt(seq_tgt),
        .run(seq_run), .bank_sel(bank_sel), .src_code(src_code), .div_f(div_f),
        .m_f(m_f), .n_f(n_f), .d_f(d_f), .dual(dual), .ctr_hold(ctr_hold)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        clkroot_bank_div #(.DIV_W(DIV_W)) u_div (
            .rst_n(rst_n), .src_clk(src_clk), .code(src_code[b]),
            .div(div_f[b]), .bank_clk(bclk[b])
        );
    end

    assign want = {bank_sel & root_en, ~bank_sel & root_en};

    clkroot_gfmux u_mux (
        .rst_n(rst_n), .bclk(bclk), .want(want), .gnt(mux_gnt), .clk_out(clk_out)
    );

    // bring grants into the system clock domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gs1 <= '0;
            gs2 <= '0;
        end else begin
            gs1 <= mux_gnt;
            gs2 <= gs1;
        end
    end
    assign handover_done = gs2[bank_sel] & ~gs2[~bank_sel];

    assign busy           = (seq_state != ST_IDLE);
    assign switch_pending = (seq_state == ST_WAIT);
    assign rd_src     = src_code[bank_sel];
    assign rd_div     = div_f[bank_sel];
    assign rd_m       = m_f[bank_sel];
    assign rd_d       = d_f[bank_sel];
    assign rd_dual    = dual[bank_sel];
    assign rd_mn_hold = ctr_hold[bank_sel];
    assign rd_n       = dual[bank_sel] ? (~n_f[bank_sel] + m_f[bank_sel]) : '0;
endmodule

// File: rtl/dual_bank_clkroot_chk.sv
module dual_bank_clkroot_chk
    import clkroot_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       switch_pending,
    input logic       bank_sel,
    input seq_state_t state,
    input logic       tgt,
    input logic       run,
    input logic [1:0] gnt
);
    p_sel_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank_sel) |-> $past(state) == ST_FLIP);

    p_md_after_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_MD |-> $past(state) == ST_RST);

    p_src_after_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SRC |-> ($past(state) == ST_REL || $past(state) == ST_IDLE));

    p_live_untouched_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (state inside {ST_RST, ST_MD, ST_N, ST_MODE, ST_REL, ST_SRC}))
        |-> tgt != bank_sel);

    p_inplace_when_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !run) |-> tgt == bank_sel);

    p_single_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    p_pending_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        switch_pending |-> busy);
endmodule

bind dual_bank_clkroot dual_bank_clkroot_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .switch_pending(switch_pending),
    .bank_sel(bank_sel), .state(seq_state), .tgt(seq_tgt), .run(seq_run),
    .gnt(mux_gnt)
);

// File: tb/sim_dual_bank_clkroot.sv
`timescale 1ns/1ps
module sim_dual_bank_clkroot;
    localparam int DIV_W = 4;
    localparam int MN_W  = 8;
    localparam int MASK  = (1 << MN_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0, root_en = 1'b0, cfg_req = 1'b0;
    logic [7:0] src_clk;
    logic [1:0] cfg_parent = '0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic [MN_W-1:0] cfg_m = '0, cfg_n = '0;
    logic busy, switch_pending, bank_sel, rd_dual, rd_mn_hold, clk_out;
    logic [2:0] rd_src;
    logic [DIV_W-1:0] rd_div;
    logic [MN_W-1:0] rd_m, rd_n, rd_d;

    int checks = 0, failures = 0, cyc = 0;
    bit done = 0, cmp_on = 0;

    always #5 clk = ~clk;

    for (genvar k = 0; k < 8; k++) begin : g_src
        logic c = 1'b0;
        initial forever #(3 + k) c = ~c;
        assign src_clk[k] = c;
    end

    dual_bank_clkroot #(.DIV_W(DIV_W), .MN_W(MN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .root_en(root_en), .src_clk(src_clk),
        .cfg_req(cfg_req), .cfg_parent(cfg_parent), .cfg_div(cfg_div),
        .cfg_m(cfg_m), .cfg_n(cfg_n), .busy(busy), .switch_pending(switch_pending),
        .bank_sel(bank_sel), .rd_src(rd_src), .rd_div(rd_div), .rd_m(rd_m),
        .rd_n(rd_n), .rd_d(rd_d), .rd_dual(rd_dual), .rd_mn_hold(rd_mn_hold),
        .clk_out(clk_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference: two banks, a step counter, a waiting flag
    int pm[4] = '{5, 2, 7, 0};
    int b_src[2], b_div[2], b_m[2], b_nf[2], b_d[2], b_dual[2], b_hold[2];
    int m_sel = 0, step = 0, tg = 0;
    bit m_run = 0, waiting = 0;
    int q_src, q_div, q_m, q_nf, q_d, q_dual;

    initial for (int i = 0; i < 2; i++) begin
        b_src[i] = 0; b_div[i] = 0; b_m[i] = 0; b_nf[i] = 0;
        b_d[i] = 0; b_dual[i] = 0; b_hold[i] = 0;
    end

    always @(posedge clk) if (rst_n) begin
        if (step == 0) begin
            if (cfg_req && !waiting) begin   // R9: ignored while busy
                q_src = pm[cfg_parent];
                q_div = (cfg_div == 0) ? 0 : int'(cfg_div) - 1;
                if (cfg_n != 0) begin
                    q_m = cfg_m; q_nf = (~(int'(cfg_n) - int'(cfg_m))) & MASK;
                    q_d = (~int'(cfg_n)) & MASK; q_dual = 1;
                end else begin
                    q_m = 0; q_nf = 0; q_d = 0; q_dual = 0;
                end
                m_run = root_en;
                tg = root_en ? 1 - m_sel : m_sel;
                step = 1;
            end
        end else begin
            case (step)
                1: b_hold[tg] = 1;
                2: begin b_m[tg] = q_m; b_d[tg] = q_d; end
                3: b_nf[tg] = q_nf;
                4: b_dual[tg] = q_dual;
                5: b_hold[tg] = 0;
                6: begin b_src[tg] = q_src; b_div[tg] = q_div; end
                7: m_sel = 1 - m_sel;
                default: ;
            endcase
            if (step == 6 && !m_run) step = 0;
            else if (step == 7) begin step = 0; waiting = 1; end
            else step++;
        end
    end

    always @(negedge clk) if (cmp_on && !done) begin
        int en;
        string fr;
        fr = (step > 0 && m_run) ? "R3" : ((step > 0) ? "R4" : "R2");
        en = b_dual[m_sel] ? ((~b_nf[m_sel] + b_m[m_sel]) & MASK) : 0;
        if (waiting && !busy) begin
            waiting = 0;
            chk(!switch_pending, "R11 pending clear", switch_pending, 0);
        end else if (waiting) begin
            chk(switch_pending && busy, "R11 pending", switch_pending, 1);
        end else begin
            chk(busy == (step > 0), "R4 busy", busy, step > 0);
        end
        chk(bank_sel == m_sel, "R2 bank_sel", bank_sel, m_sel);
        chk(rd_src == b_src[m_sel], {fr, " rd_src"}, rd_src, b_src[m_sel]);
        chk(rd_div == b_div[m_sel], {fr, " rd_div"}, rd_div, b_div[m_sel]);
        chk(rd_m == b_m[m_sel] && rd_d == b_d[m_sel], {fr, " R8 m/d"}, rd_m, b_m[m_sel]);
        chk(rd_n == en, {fr, " R8 rd_n"}, rd_n, en);
        chk(rd_dual == b_dual[m_sel], {fr, " R8 dual"}, rd_dual, b_dual[m_sel]);
        chk(rd_mn_hold == b_hold[m_sel], "R5 hold", rd_mn_hold, b_hold[m_sel]);
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy || waiting) @(negedge clk);
    endtask

    task automatic cfg(input int par, input int dv, input int m, input int n);
        @(negedge clk);
        cfg_parent = par[1:0]; cfg_div = dv[DIV_W-1:0];
        cfg_m = m[MN_W-1:0]; cfg_n = n[MN_W-1:0]; cfg_req = 1'b1;
        @(negedge clk);
        cfg_req = 1'b0;
    endtask

    task automatic period(input real exp_ns, input string req);
        realtime t1, t2;
        wait_idle();
        repeat (20) @(negedge clk);
        @(posedge clk_out); t1 = $realtime;
        @(posedge clk_out); t2 = $realtime;
        chk((t2 - t1) > exp_ns - 0.01 && (t2 - t1) < exp_ns + 0.01, req,
            int'(t2 - t1), int'(exp_ns));
    endtask

    initial begin
        root_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1;
        @(negedge clk);
        // R1 reset state
        chk(bank_sel == 0 && !busy && !switch_pending && rd_src == 0 && rd_div == 0
            && rd_m == 0 && rd_n == 0, "R1 reset", bank_sel, 0);
        repeat (5) @(negedge clk);

        cfg(1, 3, 1, 3);                 // R6 parent1 -> code2 (10ns), R7 /3
        period(30.0, "R7 period div3");
        chk(bank_sel == 1, "R2 now bank1", bank_sel, 1);

        cfg(2, 0, 2, 5);                 // R7 divisor 0 as 1, code7 (20ns)
        period(20.0, "R7 divisor0 period");
        chk(rd_n == 5 && rd_m == 2, "R8 n readback", rd_n, 5);

        cfg(0, 2, 9, 0);                 // R8 n=0 clears, code5 (16ns)
        period(32.0, "R7 period div2");
        chk(rd_m == 0 && rd_dual == 0, "R8 n zero clears", rd_m, 0);

        cfg(3, 4, 1, 2);                 // R9 second request while busy
        cfg(1, 1, 3, 3);
        wait_idle();
        chk(rd_src == 0 && rd_div == 3, "R9 busy request ignored", rd_src, 0);

        root_en = 1'b0;                  // R10 output quiet when stopped
        repeat (20) @(negedge clk);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (clk_out) begin chk(0, "R10 clk_out low", 1, 0); break; end
        end
        chk(1, "R10 quiet window", 0, 0);

        cfg(1, 5, 3, 7);                 // R4 in-place rewrite
        wait_idle();
        chk(bank_sel == 0 && rd_src == 2 && rd_div == 4, "R4 in place", rd_div, 4);
        root_en = 1'b1;
        period(50.0, "R4 period after restart");

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule